// File: doc/BRIEF.md
# Serial Ready-Status Frame Transmitter

This block drives one serial ready-status line from the egress side of a link to the ingress side. It sends the same 10-cycle frame over and over with no gap. Each frame opens with a six-cycle synchronising pattern: five zeros and then a single one. The ingress side can lock onto that pattern whatever the payload holds. Four flow-control status bits follow the pattern, least significant bit first.

Two of the status bits come straight from input ports. They are the control-ready and data-ready flags taken from the most recent fabric frame headers. The other two bits are computed locally from three buffer fill levels, each compared with its own programmable high-water mark:

- the control partition of the receive buffer,
- the data partition of the receive buffer,
- the egress flow-control queue, which holds 256 words.

The four bits are captured once per frame. A frame therefore never mixes old and new values. The value that has just been sent is shown on a status output for register logic nearby.

Top module: `rdy_serial_tx`

## Requirements
- R1: A frame lasts exactly 10 clock cycles, numbered 0 to 9, and each frame starts in the cycle right after cycle 9 of the previous one.
- R2: During cycles 0 to 5 of every frame, `link_o` carries 0,0,0,0,0,1 in that order, so it is 1 only in cycle 5.
- R3: During cycles 6, 7, 8 and 9, `link_o` carries status bits 0, 1, 2 and 3 of the captured status. Bit 0 is the fabric control-ready flag (`fab_ctl_rdy_i`) and bit 1 is the fabric data-ready flag (`fab_dat_rdy_i`).
- R4: Status bit 2 (local control ready) is 0 when the control-partition level is at or above its mark, or when the flow-control queue level is at or above its mark. Otherwise it is 1.
- R5: Status bit 3 (local data ready) is 0 when the data-partition level is at or above its mark. Otherwise it is 1.
- R6: Levels and marks are 9-bit unsigned values, so the whole range 0 to 256 of the 256-entry queue compares correctly. A level of 256 with a mark of 256 counts as full. A mark of 0 always counts as full.
- R7: The status is captured only at the clock edge that ends cycle 9. Any input change made during cycles 0 to 8 has no effect on the bits sent in the current frame.
- R8: `sent_stat_o` changes only at the edge that ends a frame. It then takes the four bits that frame carried. It is 0 after reset.
- R9: A synchronous active-high reset drives `link_o` to 0 and holds the frame at cycle 0. The first frame after reset carries status 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fab_ctl_rdy_i | input | 1 | Latched fabric control-ready flag |
| fab_dat_rdy_i | input | 1 | Latched fabric data-ready flag |
| rb_ctl_lvl_i | input | LVL_W | Receive buffer control partition fill level |
| rb_ctl_mark_i | input | LVL_W | Control partition high-water mark |
| rb_dat_lvl_i | input | LVL_W | Receive buffer data partition fill level |
| rb_dat_mark_i | input | LVL_W | Data partition high-water mark |
| fcq_lvl_i | input | LVL_W | Egress flow-control queue fill level |
| fcq_mark_i | input | LVL_W | Flow-control queue high-water mark |
| link_o | output | 1 | Serial ready-status line |
| sent_stat_o | output | 4 | Status bits of the last completed frame |

## Verification
The bench builds the block with its default 9-bit levels. This lets it drive the extreme queue values 255 and 256 against a mark of 256, alongside marks of 0 and levels one below or equal to a mark. One frame changes the inputs in cycles 0 to 8 and restores them in cycle 9, to show that capture happens only at the frame boundary. The bench follows the frame position with its own counter, starting from reset release. It compares each complete 10-bit frame with the expected one.

// File: rtl/rdy_serial_pkg.sv
package rdy_serial_pkg;
  localparam int PRE_LEN   = 6;
  localparam int NBITS     = 4;
  localparam int FRAME_LEN = PRE_LEN + NBITS;
  localparam int PHASE_W   = $clog2(FRAME_LEN);
  localparam int SEL_W     = $clog2(NBITS);
  localparam int NMARKS    = 3;

  // index of each watermark comparator
  localparam int MK_CTL = 0;
  localparam int MK_DAT = 1;
  localparam int MK_FCQ = 2;

  typedef logic [NBITS-1:0] stat_t;

  // level at or above mark counts as full
  function automatic logic at_mark(input logic [15:0] lvl, input logic [15:0] mark);
    return lvl >= mark;
  endfunction

  // status nibble: bit0 fabric ctl, bit1 fabric data, bit2 local ctl, bit3 local data
  function automatic stat_t pack_status(input logic fab_c, input logic fab_d,
                                        input logic ctl_full, input logic dat_full,
                                        input logic fcq_full);
    stat_t s;
    s[0] = fab_c;
    s[1] = fab_d;
    s[2] = ~(ctl_full | fcq_full);
    s[3] = ~dat_full;
    return s;
  endfunction

  // synchronising pattern bit for a preamble position
  function automatic logic sync_bit(input int unsigned pos);
    return pos == PRE_LEN - 1;
  endfunction
endpackage

// File: rtl/rdy_mark_cmp.sv
module rdy_mark_cmp #(
  parameter int LVL_W = 9
) (
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] mark_i,
  output logic             full_o
);
  import rdy_serial_pkg::*;

  always_comb full_o = at_mark(16'(lvl_i), 16'(mark_i));
endmodule

// File: rtl/rdy_frame_seq.sv
module rdy_frame_seq
  import rdy_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase_o,
  output logic               frame_end_o
);
  localparam logic [PHASE_W-1:0] LAST = PHASE_W'(FRAME_LEN - 1);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                    phase_q <= phase_q + 1'b1;
  end

  assign phase_o     = phase_q;
  assign frame_end_o = (phase_q == LAST);

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> (phase_o == '0));
  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase_o < PHASE_W'(FRAME_LEN));
  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end_o |=> (phase_o == $past(phase_o) + 1'b1));
endmodule

// File: rtl/rdy_serial_tx.sv
module rdy_serial_tx
  import rdy_serial_pkg::*;
#(
  parameter int LVL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fab_ctl_rdy_i,
  input  logic             fab_dat_rdy_i,
  input  logic [LVL_W-1:0] rb_ctl_lvl_i,
  input  logic [LVL_W-1:0] rb_ctl_mark_i,
  input  logic [LVL_W-1:0] rb_dat_lvl_i,
  input  logic [LVL_W-1:0] rb_dat_mark_i,
  input  logic [LVL_W-1:0] fcq_lvl_i,
  input  logic [LVL_W-1:0] fcq_mark_i,
  output logic             link_o,
  output logic [3:0]       sent_stat_o
);
  logic [LVL_W-1:0] lvl_arr  [NMARKS];
  logic [LVL_W-1:0] mark_arr [NMARKS];
  logic [NMARKS-1:0] full_w;

  assign lvl_arr[MK_CTL]  = rb_ctl_lvl_i;
  assign mark_arr[MK_CTL] = rb_ctl_mark_i;
  assign lvl_arr[MK_DAT]  = rb_dat_lvl_i;
  assign mark_arr[MK_DAT] = rb_dat_mark_i;
  assign lvl_arr[MK_FCQ]  = fcq_lvl_i;
  assign mark_arr[MK_FCQ] = fcq_mark_i;

  for (genvar g = 0; g < NMARKS; g++) begin : g_mark
    rdy_mark_cmp #(.LVL_W(LVL_W)) u_cmp (
      .lvl_i  (lvl_arr[g]),
      .mark_i (mark_arr[g]),
      .full_o (full_w[g])
    );
  end

  // named events for the checks
  logic ctl_full_w, dat_full_w, fcq_full_w;
  assign ctl_full_w = full_w[MK_CTL];
  assign dat_full_w = full_w[MK_DAT];
  assign fcq_full_w = full_w[MK_FCQ];

  stat_t next_stat_w;
  assign next_stat_w = pack_status(fab_ctl_rdy_i, fab_dat_rdy_i,
                                   ctl_full_w, dat_full_w, fcq_full_w);

  logic [PHASE_W-1:0] phase_w;
  logic               frame_end_w;

  rdy_frame_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .phase_o     (phase_w),
    .frame_end_o (frame_end_w)
  );

  stat_t hold_q, sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      sent_q <= '0;
    end else if (frame_end_w) begin
      sent_q <= hold_q;
      hold_q <= next_stat_w;
    end
  end

  logic             in_pre_w;
  logic [PHASE_W-1:0] bit_pos_w;
  assign in_pre_w  = phase_w < PHASE_W'(PRE_LEN);
  assign bit_pos_w = phase_w - PHASE_W'(PRE_LEN);

  always_comb begin
    if (in_pre_w) link_o = sync_bit(32'(phase_w));
    else          link_o = hold_q[bit_pos_w[SEL_W-1:0]];
  end

  assign sent_stat_o = sent_q;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end_w |=> $stable(hold_q));
  // R8
  sent_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_end_w |=> $stable(sent_stat_o));
  // R8
  sent_update_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_w |=> (sent_stat_o == $past(hold_q)));
  // R4
  ctl_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end_w && (ctl_full_w || fcq_full_w)) |=> !hold_q[2]);
  // R5
  dat_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_end_w && dat_full_w) |=> !hold_q[3]);
  // R2
  sync_one_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_w == PHASE_W'(PRE_LEN - 1)) |-> link_o);
  // R2
  sync_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_w < PHASE_W'(PRE_LEN - 1)) |-> !link_o);
  // R9
  reset_line_chk: assert property (@(posedge clk)
    $past(rst) |-> (phase_w == '0 && !link_o));
endmodule

// File: tb/rdy_serial_tx_tb.sv
module rdy_serial_tx_tb;
  localparam int LW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fc = 1'b0, fd = 1'b0;
  logic [LW-1:0] cl = '0, cm = '0, dl = '0, dm = '0, ql = '0, qm = '0;
  logic link;
  logic [3:0] sent;

  int n_chk = 0;
  int n_bad = 0;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  typedef struct {
    logic [3:0] st;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  rdy_serial_tx #(.LVL_W(LW)) u_dut (
    .clk(clk), .rst(rst),
    .fab_ctl_rdy_i(fc), .fab_dat_rdy_i(fd),
    .rb_ctl_lvl_i(cl), .rb_ctl_mark_i(cm),
    .rb_dat_lvl_i(dl), .rb_dat_mark_i(dm),
    .fcq_lvl_i(ql), .fcq_mark_i(qm),
    .link_o(link), .sent_stat_o(sent)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected status, restated from the requirements
  function automatic logic [3:0] model(input logic c, input logic d,
      input int ctl_l, input int ctl_m, input int dat_l, input int dat_m,
      input int q_l, input int q_m);
    logic loc_c, loc_d;
    loc_c = (ctl_l < ctl_m) && (q_l < q_m);
    loc_d = dat_l < dat_m;
    return {loc_d, loc_c, d, c};
  endfunction

  task automatic apply(input logic c, input logic d, input int a, input int b,
                       input int e, input int f, input int g, input int h);
    fc = c; fd = d;
    cl = LW'(a); cm = LW'(b); dl = LW'(e); dm = LW'(f); ql = LW'(g); qm = LW'(h);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // drive one vector at cycle 0 and queue its expected frame
  task automatic send(input string tag, input logic c, input logic d, input int a,
                      input int b, input int e, input int f, input int g, input int h);
    exp_t x;
    apply(c, d, a, b, e, f, g, h);
    x.st = model(c, d, a, b, e, f, g, h);
    x.tag = tag;
    exp_q.push_back(x);
    tick(10);
  endtask

  // monitor: rebuild each frame and compare with the scoreboard
  int unsigned pos = 0;
  logic [9:0] bits;
  logic [3:0] last_sent = 4'h0;
  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      if (pos == 0)
        check(sent === last_sent, "R8 sent status", int'(sent), int'(last_sent));
      bits[pos] = link;
      if (pos == 9) begin
        if (exp_q.size() > 0) begin
          exp_t x;
          x = exp_q.pop_front();
          check(bits[5:0] === 6'b100000, "R1 R2 preamble", int'(bits[5:0]), 32);
          check(bits[9:6] === x.st, x.tag, int'(bits[9:6]), int'(x.st));
          last_sent = x.st;
        end
        pos = 0;
      end else begin
        pos++;
      end
    end
  end

  initial begin
    exp_t x0;
    tick(3);
    // R9: reset state
    check(link === 1'b0, "R9 line low in reset", int'(link), 0);
    check(sent === 4'h0, "R9 sent zero in reset", int'(sent), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    x0.st = 4'h0;
    x0.tag = "R9 first frame status";
    exp_q.push_back(x0);
    send("R3 R4 R5 fabric ctl only", 1, 0, 10, 200, 10, 200, 10, 200);
    send("R3 R4 ctl at mark", 0, 1, 100, 100, 0, 50, 0, 50);
    send("R4 R6 queue 256 of 256", 1, 1, 99, 100, 0, 50, 256, 256);
    send("R5 R6 data 256 of 256", 0, 0, 0, 5, 256, 256, 255, 256);
    send("R5 R6 data 255 of 256, ctl mark zero", 1, 0, 0, 0, 255, 256, 0, 9);
    send("R3 R4 R5 all ready", 1, 1, 1, 2, 3, 4, 5, 6);
    // R7: junk in cycles 0..8, restored in cycle 9
    begin
      exp_t xr;
      apply(0, 0, 300, 1, 300, 1, 300, 1);
      tick(9);
      apply(0, 1, 7, 8, 20, 20, 0, 1);
      xr.st = model(0, 1, 7, 8, 20, 20, 0, 1);
      xr.tag = "R7 capture at frame end";
      exp_q.push_back(xr);
      tick(1);
    end
    send("R4 R5 both full", 1, 1, 300, 256, 511, 0, 0, 0);
    send("R1 R3 nothing full", 0, 0, 0, 1, 0, 1, 0, 1);
    while (exp_q.size() > 0) tick(1);
    tick(12);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule